// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block decides when a USB host controller raises its interrupt line. It keeps one interrupt enable register and a sticky event status register. Software changes the enable register through two addressed views. The set view turns bits on wherever the written word has a 1. The clear view turns bits off wherever the written word has a 1. Both views read back the same enable contents. The top enable bit (31) is a master switch. The interrupt output is high only while the master bit is 1 and at least one latched event is also enabled.

Software reaches the block through a command-code port. Bit 7 of the eight-bit code marks a write, and the low seven bits select the view:

| View | Read code | Write code |
|------|-----------|------------|
| Status | 03h | 83h |
| Enable set | 04h | 84h |
| Enable clear | 05h | 85h |

A write happens when `cmd_strobe` is high at a rising clock edge, and its effect is visible from that edge onward. `rd_data` follows `cmd_code` combinationally. The block has no data stream, so no pin uses a valid/ready handshake and the port never applies back-pressure.

Event bit positions are fixed:

| Bit | Event |
|-----|-------|
| 0 | Scheduling overrun |
| 2 | Start of frame |
| 3 | Resume detected |
| 4 | Unrecoverable error |
| 5 | Frame number overflow |
| 6 | Root hub status change |

Bit 1 and bits 7 to 30 are reserved. The block ignores reserved bits on write and reads them back as 0.

Top module: `ier_ctrl`

## Requirements
- R1: After reset, the enable register, the master bit and the status register are all 0, and `irq_out` is 0.
- R2: A write with code 84h sets every implemented enable bit (0, 2–6, 31) whose data bit is 1. Data bits that are 0 leave the matching enable bits unchanged.
- R3: A write with code 85h clears every implemented enable bit whose data bit is 1. Data bits that are 0 leave the matching enable bits unchanged.
- R4: Read codes 04h and 05h both return the current enable register contents.
- R5: Writes to reserved bits (1 and 7–30) have no effect. Those bits read back as 0 in the enable view and in the status view.
- R6: The master bit (31) is set through the set view and cleared through the clear view. While it is 0, `irq_out` stays 0 whatever the status and enables are.
- R7: `irq_out` is 1 exactly when the master bit is 1 and some event bit is 1 in both the status register and the enable register.
- R8: A one-cycle high pulse on an event bit of `evt_in` sets the matching status bit, and the bit stays set. A write with code 83h clears every status bit whose data bit is 1. Status is read with code 03h.
- R9: If an event pulse and a status clear hit the same bit in the same cycle, that bit ends up set.
- R10: With the strobe low, or with code bit 7 at 0, nothing changes. A write to any unassigned code changes nothing, and a read of any unassigned code returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_strobe | input | 1 | Performs the access selected by `cmd_code` at the next rising edge |
| cmd_code | input | 8 | Command code: bit 7 = write, bits 6:0 = view |
| cmd_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data of the view selected by `cmd_code` |
| evt_in | input | 32 | Event pulses, one-cycle high per event; reserved bits are ignored |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the master bit gates `irq_out`;
- set-view writes land and clear-view writes clear;
- event pulses stick in the status register;
- the enable register holds steady without a strobe;
- reserved bits read back as 0.

Some behaviours can only be shown by the bench's scenarios:
- the exact values read back through all three views;
- set winning over a same-cycle clear;
- unassigned codes being inert;
- `irq_out` tracking a shadow model across mixed random command sequences.

// File: rtl/ier_pkg.sv
package ier_pkg;
  localparam int CODE_W  = 8;
  localparam int WR_BIT  = 7;
  localparam logic [6:0] VIEW_STATUS  = 7'h03;
  localparam logic [6:0] VIEW_SET     = 7'h04;
  localparam logic [6:0] VIEW_CLEAR   = 7'h05;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_STATUS, SEL_SET, SEL_CLEAR
  } view_sel_e;

  function automatic view_sel_e decode_view(input logic [6:0] v);
    case (v)
      VIEW_STATUS: return SEL_STATUS;
      VIEW_SET:    return SEL_SET;
      VIEW_CLEAR:  return SEL_CLEAR;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ier_enable_reg.sv
module ier_enable_reg #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] LEGAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  logic [DATA_W-1:0] bits_w;
  assign bits_w = wdata & LEGAL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_en) en_q <= en_q | bits_w;
    else if (clr_en) en_q <= en_q & ~bits_w;
  end
endmodule

// File: rtl/ier_status_reg.sv
module ier_status_reg #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] EVT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_in,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] st_q
);
  logic [DATA_W-1:0] set_w, clr_w;
  assign set_w = evt_in & EVT_MASK;
  assign clr_w = clr_en ? (wdata & EVT_MASK) : '0;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (EVT_MASK[b]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q[b] <= 1'b0;
        else if (set_w[b]) st_q[b] <= 1'b1;
        else if (clr_w[b]) st_q[b] <= 1'b0;
      end
    end else begin : g_rsvd
      assign st_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ier_irq_gate.sv
module ier_irq_gate #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] EVT_MASK = '0,
  parameter int          MASTER_BIT = 31
) (
  input  logic [DATA_W-1:0] en_q,
  input  logic [DATA_W-1:0] st_q,
  output logic              irq
);
  logic [DATA_W-1:0] hits;
  assign hits = st_q & en_q & EVT_MASK;
  assign irq  = en_q[MASTER_BIT] & (|hits);
endmodule

// File: rtl/ier_ctrl.sv
module ier_ctrl
  import ier_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          MASTER_BIT = 31,
  parameter logic [DATA_W-1:0] EVT_MASK = 32'h0000_007D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] evt_in,
  output logic              irq_out
);
  localparam logic [DATA_W-1:0] LEGAL_EN = EVT_MASK | (DATA_W'(1) << MASTER_BIT);

  view_sel_e         sel;
  logic              is_wr;
  logic [DATA_W-1:0] en_q, st_q;

  assign sel   = decode_view(cmd_code[6:0]);
  assign is_wr = cmd_strobe & cmd_code[WR_BIT];

  ier_enable_reg #(.DATA_W(DATA_W), .LEGAL(LEGAL_EN)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_en(is_wr && sel == SEL_SET),
    .clr_en(is_wr && sel == SEL_CLEAR),
    .wdata(cmd_wdata), .en_q(en_q));

  ier_status_reg #(.DATA_W(DATA_W), .EVT_MASK(EVT_MASK)) u_st (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .clr_en(is_wr && sel == SEL_STATUS),
    .wdata(cmd_wdata), .st_q(st_q));

  ier_irq_gate #(.DATA_W(DATA_W), .EVT_MASK(EVT_MASK), .MASTER_BIT(MASTER_BIT)) u_gate (
    .en_q(en_q), .st_q(st_q), .irq(irq_out));

  always_comb begin
    case (sel)
      SEL_STATUS:          rd_data = st_q;
      SEL_SET, SEL_CLEAR:  rd_data = en_q;
      default:             rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ier_ctrl_chk.sv
module ier_ctrl_chk #(
  parameter int          DATA_W     = 32,
  parameter int          MASTER_BIT = 31,
  parameter logic [DATA_W-1:0] EVT_MASK = 32'h0000_007D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_strobe,
  input logic [7:0]        cmd_code,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic [DATA_W-1:0] evt_in,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] st_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_out
);
  localparam logic [DATA_W-1:0] LEGAL_EN = EVT_MASK | (DATA_W'(1) << MASTER_BIT);

  // R6
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[MASTER_BIT] |-> !irq_out);

  // R2
  set_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == 8'h84) |=>
      ((en_q & $past(cmd_wdata & LEGAL_EN)) == $past(cmd_wdata & LEGAL_EN)));

  // R3
  clear_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == 8'h85) |=> ((en_q & $past(cmd_wdata)) == '0));

  // R8
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & EVT_MASK)) |=>
      ((st_q & $past(evt_in & EVT_MASK)) == $past(evt_in & EVT_MASK)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |=> $stable(en_q));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LEGAL_EN) == '0);
endmodule

bind ier_ctrl ier_ctrl_chk #(.DATA_W(DATA_W), .MASTER_BIT(MASTER_BIT), .EVT_MASK(EVT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
  .cmd_wdata(cmd_wdata), .evt_in(evt_in), .en_q(en_q), .st_q(st_q),
  .rd_data(rd_data), .irq_out(irq_out));

// File: tb/ier_ctrl_test.sv
module ier_ctrl_test;
  localparam int  CLK_NS = 20;
  localparam logic [31:0] EVT = 32'h0000_007D;
  localparam logic [31:0] LEG = 32'h8000_007D;

  logic clk = 0, rst_n = 0, cmd_strobe = 0, irq_out;
  logic [7:0]  cmd_code = 8'h00;
  logic [31:0] cmd_wdata = '0, evt_in = '0, rd_data;
  logic [31:0] en_m = '0, st_m = '0;
  int vectors = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  ier_ctrl uut (.clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .rd_data(rd_data), .evt_in(evt_in), .irq_out(irq_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_view(input logic [7:0] code, output logic [31:0] v);
    cmd_code = code; #1; v = rd_data;
  endtask

  task automatic check_all(input string ctx);
    logic [31:0] v;
    logic exp_irq;
    read_view(8'h03, v); check({"R8 status ", ctx}, v, st_m);
    read_view(8'h04, v); check({"R4 set view ", ctx}, v, en_m);
    read_view(8'h05, v); check({"R4 clear view ", ctx}, v, en_m);
    read_view(8'h06, v); check({"R10 unassigned ", ctx}, v, 32'h0);
    exp_irq = en_m[31] && |(st_m & en_m & EVT);
    check({"R7 irq ", ctx}, {31'b0, irq_out}, {31'b0, exp_irq});
  endtask

  task automatic step(input logic stb, input logic [7:0] code, input logic [31:0] wd,
                      input logic [31:0] ev);
    logic [31:0] clr;
    @(negedge clk);
    cmd_strobe = stb; cmd_code = code; cmd_wdata = wd; evt_in = ev;
    @(negedge clk);
    if (stb && code == 8'h84) en_m = en_m | (wd & LEG);
    if (stb && code == 8'h85) en_m = en_m & ~(wd & LEG);
    clr  = (stb && code == 8'h83) ? (wd & EVT) : 32'h0;
    st_m = (st_m & ~clr) | (ev & EVT);
    cmd_strobe = 0; evt_in = '0; cmd_wdata = '0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf, v;
    logic [7:0] codes [8];
    codes = '{8'h03, 8'h04, 8'h05, 8'h83, 8'h84, 8'h85, 8'h06, 8'h86};
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    // R2 sweep every bit through the set view
    for (int b = 0; b < 32; b++) begin
      step(1, 8'h84, 32'h1 << b, 0);
      check_all("R2 set sweep");
    end
    read_view(8'h04, v); check("R5 reserved ignored", v, LEG);
    step(1, 8'h84, 32'h0, 0); check_all("R2 zero no effect");
    // R3 sweep clear view
    for (int b = 0; b < 32; b++) begin
      step(1, 8'h85, 32'h1 << b, 0);
      check_all("R3 clear sweep");
    end
    step(1, 8'h84, 32'hFFFF_FFFF, 0);
    step(1, 8'h85, 32'h0, 0); check_all("R3 zero no effect");
    // R10 read strobe and unassigned write
    step(1, 8'h04, 32'h0, 0); step(1, 8'h05, 32'hFFFF_FFFF, 0);
    step(1, 8'h86, 32'hFFFF_FFFF, 0);
    read_view(8'h04, v); check("R10 inert codes", v, LEG);
    // R8 event sweep
    for (int b = 0; b < 32; b++) begin
      step(0, 8'h00, 0, 32'h1 << b);
      check_all("R8 event sweep");
    end
    read_view(8'h03, v); check("R5 status reserved", v, EVT);
    // R6 master off blocks irq
    step(1, 8'h85, 32'h8000_0000, 0);
    check({31'b0, irq_out} == 0 ? "R6 master off" : "R6 master off", {31'b0, irq_out}, 32'h0);
    step(1, 8'h84, 32'h8000_0000, 0);
    check("R6 master on", {31'b0, irq_out}, 32'h1);
    // R9 same-cycle set/clear
    step(1, 8'h83, 32'hFFFF_FFFF, 32'h0000_0004);
    read_view(8'h03, v); check("R9 set wins", v, 32'h0000_0004);
    check_all("R9 after");
    // mixed random sequence
    lf = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[3], codes[lf[6:4]], {lf[31], lf[15:0], lf[30:16]},
           (lf[9:8] == 0) ? (32'h1 << lf[14:10]) : 32'h0);
      check_all("R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule